// File: doc/BRIEF.md
# Critical-Group-First Instruction Block Fill Sequencer

This block moves one 64-parcel instruction block from an interleaved main store into an instruction buffer. The block is split into four groups of 16 parcels. Each group is four 64-bit bank words, so one group is read from four banks at once. The sequencer issues one group read per clock. It starts with the group that holds the parcel the fetch logic is waiting for, then continues in circular order through the rest of the block.

The store answers with a fixed delay. The sequencer counts that delay itself and needs no handshake from the store. The first group reaches the buffer write port exactly 14 clocks after the start is accepted, whatever the offset. The other three groups follow on the next three clocks. For the whole transfer the sequencer holds an inhibit line high to block every other store request. Requests, writes and the done pulse all come from one cycle counter.

Top module: `fill_seq`

## Requirements
- R1: After reset `inhibit_o`, `bank_req_o`, `buf_we_o` and `done_o` are all low.
- R2: A start sampled while idle is accepted: `inhibit_o` is high from the cycle after that edge (cycle 0) through cycle 17 and is low in cycle 18.
- R3: Requests go out in cycles 0 to 3, one group per cycle. The first group index is `offset_i[5:4]`, and each later index is the previous one plus one, modulo 4. For group g, bits 4g to 4g+3 of `bank_req_o` are set, and `req_addr_o` is `{base, g[1:0], 4'b0000}`.
- R4: `buf_we_o` is high in cycles 14 to 17 and low in every other cycle of the fill, for every offset.
- R5: The write in cycle 14+k carries group index (first+k) mod 4 on `buf_group_o`, and `buf_wdata_o` holds the `rd_data_i` value sampled in the previous cycle.
- R6: `done_o` is high for exactly one cycle, cycle 18, one clock after the last write. `inhibit_o` drops in that same cycle.
- R7: A start pulse, with any base or offset, that arrives while a fill is in progress is ignored. The running fill keeps its order and timing, and no extra fill follows.
- R8: A start in the done cycle is accepted, so two fills can run back to back.
- R9: Over one fill, every one of the 16 bank request bits is set exactly once. In any single cycle either no bank bit or exactly four bank bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to fill one block |
| base_i | input | 16 | Block base (parcel address bits 21:6) |
| offset_i | input | 6 | Offset of the needed parcel within the block |
| rd_data_i | input | 256 | Returned group: four bank words, bank 0 in the low bits |
| bank_req_o | output | 16 | Per-bank read request mask |
| req_addr_o | output | 22 | Parcel address of the group being requested |
| inhibit_o | output | 1 | Holds off all other store requests |
| buf_we_o | output | 1 | Buffer group write enable |
| buf_group_o | output | 2 | Index of the group being written |
| buf_wdata_o | output | 256 | Group data to the buffer |
| done_o | output | 1 | One-cycle pulse when the fill is complete |

## Verification
Two cases are hard to reach from the ports. The first is a start pulse that lands while a fill is still running; the second is a fill that begins in the done cycle of the one before. The bench reaches the first by raising start, with a different base and offset, once during the request cycles and once during the write cycles. It then checks every cycle of the running fill against the schedule it expected before the stray pulse. For the second, it chains two fills so that the second start is driven during cycle 18 of the first, and it checks both complete schedules. A delay-line store model in the bench returns data for the address that was actually requested. This exposes any mismatch between the requested group and the written group.

// File: rtl/fill_seq_pkg.sv
package fill_seq_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} fill_state_e;
endpackage

// File: rtl/fill_seq_ctl.sv
module fill_seq_ctl #(
  parameter int LATENCY    = 14,
  parameter int NUM_GROUPS = 4,
  parameter int CNT_W      = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] cyc_o,
  output logic             cap_o,
  output logic             done_o
);
  import fill_seq_pkg::*;

  localparam int CAP_FIRST = LATENCY - 1;
  localparam int CAP_LAST  = LATENCY + NUM_GROUPS - 2;
  localparam int END_CYC   = LATENCY + NUM_GROUPS - 1;

  fill_state_e      state_q;
  logic [CNT_W-1:0] cyc_q;
  logic             done_q;
  logic             last_cyc;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign last_cyc = (state_q == ST_BUSY) && (cyc_q == CNT_W'(END_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_cyc;
      if (accept_o) begin
        state_q <= ST_BUSY;
        cyc_q   <= '0;
      end else if (last_cyc) begin
        state_q <= ST_IDLE;
        cyc_q   <= '0;
      end else if (state_q == ST_BUSY) begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  assign busy_o = (state_q == ST_BUSY);
  assign cyc_o  = cyc_q;
  assign cap_o  = busy_o && (cyc_q >= CNT_W'(CAP_FIRST)) && (cyc_q <= CNT_W'(CAP_LAST));
  assign done_o = done_q;
endmodule

// File: rtl/fill_seq_issue.sv
module fill_seq_issue #(
  parameter int NUM_GROUPS      = 4,
  parameter int BANKS_PER_GROUP = 4,
  parameter int GRP_W           = 2,
  parameter int PIN_W           = 4,
  parameter int BASE_W          = 16,
  parameter int ADDR_W          = 22,
  parameter int CNT_W           = 5,
  localparam int NUM_BANKS      = NUM_GROUPS * BANKS_PER_GROUP
) (
  input  logic                 busy_i,
  input  logic [CNT_W-1:0]     cyc_i,
  input  logic [GRP_W-1:0]     first_grp_i,
  input  logic [BASE_W-1:0]    base_i,
  output logic [NUM_BANKS-1:0] bank_req_o,
  output logic [ADDR_W-1:0]    req_addr_o
);
  logic             req_act;
  logic [GRP_W-1:0] req_grp;

  assign req_act = busy_i && (cyc_i < CNT_W'(NUM_GROUPS));
  assign req_grp = first_grp_i + cyc_i[GRP_W-1:0];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign bank_req_o[g*BANKS_PER_GROUP +: BANKS_PER_GROUP] =
      {BANKS_PER_GROUP{req_act && (req_grp == GRP_W'(g))}};
  end

  assign req_addr_o = req_act ? {base_i, req_grp, {PIN_W{1'b0}}} : '0;
endmodule

// File: rtl/fill_seq_write.sv
module fill_seq_write #(
  parameter int GRP_W   = 2,
  parameter int GROUP_W = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_i,
  input  logic [GRP_W-1:0]   grp_i,
  input  logic [GROUP_W-1:0] rd_data_i,
  output logic               we_o,
  output logic [GRP_W-1:0]   grp_o,
  output logic [GROUP_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      grp_o  <= '0;
      data_o <= '0;
    end else begin
      we_o <= cap_i;
      if (cap_i) begin
        grp_o  <= grp_i;
        data_o <= rd_data_i;
      end
    end
  end
endmodule

// File: rtl/fill_seq.sv
module fill_seq #(
  parameter int PARCEL_W      = 16,
  parameter int GROUP_PARCELS = 16,
  parameter int NUM_GROUPS    = 4,
  parameter int BANK_W        = 64,
  parameter int LATENCY       = 14,
  parameter int ADDR_W        = 22,
  localparam int BLOCK_PARCELS    = GROUP_PARCELS * NUM_GROUPS,
  localparam int OFF_W            = $clog2(BLOCK_PARCELS),
  localparam int GRP_W            = $clog2(NUM_GROUPS),
  localparam int PIN_W            = $clog2(GROUP_PARCELS),
  localparam int BASE_W           = ADDR_W - OFF_W,
  localparam int PARCELS_PER_WORD = BANK_W / PARCEL_W,
  localparam int BANKS_PER_GROUP  = GROUP_PARCELS / PARCELS_PER_WORD,
  localparam int NUM_BANKS        = BANKS_PER_GROUP * NUM_GROUPS,
  localparam int GROUP_W          = BANKS_PER_GROUP * BANK_W,
  localparam int CNT_W            = $clog2(LATENCY + NUM_GROUPS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [BASE_W-1:0]    base_i,
  input  logic [OFF_W-1:0]     offset_i,
  input  logic [GROUP_W-1:0]   rd_data_i,
  output logic [NUM_BANKS-1:0] bank_req_o,
  output logic [ADDR_W-1:0]    req_addr_o,
  output logic                 inhibit_o,
  output logic                 buf_we_o,
  output logic [GRP_W-1:0]     buf_group_o,
  output logic [GROUP_W-1:0]   buf_wdata_o,
  output logic                 done_o
);
  logic             accept, busy, cap;
  logic [CNT_W-1:0] cyc;
  logic [BASE_W-1:0] base_q;
  logic [GRP_W-1:0]  first_q;
  logic [GRP_W-1:0]  wr_grp;

  fill_seq_ctl #(
    .LATENCY(LATENCY), .NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W)
  ) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .accept_o(accept), .busy_o(busy), .cyc_o(cyc),
    .cap_o(cap), .done_o(done_o)
  );

  // request context is frozen for the whole fill
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      first_q <= '0;
    end else if (accept) begin
      base_q  <= base_i;
      first_q <= offset_i[OFF_W-1 -: GRP_W];
    end
  end

  fill_seq_issue #(
    .NUM_GROUPS(NUM_GROUPS), .BANKS_PER_GROUP(BANKS_PER_GROUP),
    .GRP_W(GRP_W), .PIN_W(PIN_W), .BASE_W(BASE_W),
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_issue (
    .busy_i(busy), .cyc_i(cyc), .first_grp_i(first_q), .base_i(base_q),
    .bank_req_o(bank_req_o), .req_addr_o(req_addr_o)
  );

  // capture slot k sits at cyc = LATENCY-1+k
  assign wr_grp = first_q + GRP_W'(cyc - CNT_W'(LATENCY - 1));

  fill_seq_write #(.GRP_W(GRP_W), .GROUP_W(GROUP_W)) u_write (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap), .grp_i(wr_grp),
    .rd_data_i(rd_data_i), .we_o(buf_we_o), .grp_o(buf_group_o),
    .data_o(buf_wdata_o)
  );

  assign inhibit_o = busy;
endmodule

// File: rtl/fill_seq_chk.sv
module fill_seq_chk #(
  parameter int NUM_BANKS  = 16,
  parameter int GRP_W      = 2,
  parameter int LATENCY    = 14,
  parameter int NUM_GROUPS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic [NUM_BANKS-1:0] bank_req_o,
  input logic                 inhibit_o,
  input logic                 buf_we_o,
  input logic [GRP_W-1:0]     buf_group_o,
  input logic                 done_o
);
  localparam int CW = $clog2(LATENCY + NUM_GROUPS + 2) + 1;
  logic [CW-1:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_q <= '0;
    else if (!inhibit_o) since_q <= '0;
    else if (since_q != '1) since_q <= since_q + 1'b1;
  end

  a_r2_req_under_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_req_o != '0) |-> inhibit_o);
  a_r9_four_banks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(bank_req_o) == 0) || ($countones(bank_req_o) == 4));
  a_r4_write_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> (inhibit_o && since_q >= CW'(LATENCY) && since_q < CW'(LATENCY + NUM_GROUPS)));
  a_r4_first_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_o && since_q == CW'(LATENCY)) |-> buf_we_o);
  a_r5_group_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_we_o && $past(buf_we_o)) |-> (buf_group_o == $past(buf_group_o) + 1'b1));
  a_r6_done_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!inhibit_o && $past(buf_we_o)));
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_busy_start_no_reissue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && inhibit_o && bank_req_o == '0) |=> (bank_req_o == '0));
endmodule

bind fill_seq fill_seq_chk #(
  .NUM_BANKS(NUM_BANKS), .GRP_W(GRP_W), .LATENCY(LATENCY), .NUM_GROUPS(NUM_GROUPS)
) u_fill_seq_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .bank_req_o(bank_req_o),
  .inhibit_o(inhibit_o), .buf_we_o(buf_we_o), .buf_group_o(buf_group_o),
  .done_o(done_o)
);

// File: tb/fill_seq_test.sv
module fill_seq_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [15:0]  base_i = '0;
  logic [5:0]   offset_i = '0;
  logic [255:0] rd_data_i;
  logic [15:0]  bank_req_o;
  logic [21:0]  req_addr_o;
  logic         inhibit_o, buf_we_o, done_o;
  logic [1:0]   buf_group_o;
  logic [255:0] buf_wdata_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  fill_seq uut (.*);

  // store model: data for a requested address appears 12 edges after sampling
  logic        dl_v [13];
  logic [21:0] dl_a [13];

  function automatic logic [255:0] pat(input logic [21:0] a);
    logic [255:0] r;
    for (int j = 0; j < 4; j++) r[j*64 +: 64] = {10'h0, a, 30'h0, 2'(j)};
    return r;
  endfunction

  always @(posedge clk_i) begin
    dl_v[0] <= |bank_req_o;
    dl_a[0] <= req_addr_o;
    for (int i = 1; i < 13; i++) begin
      dl_v[i] <= dl_v[i-1];
      dl_a[i] <= dl_a[i-1];
    end
  end
  assign rd_data_i = dl_v[12] ? pat(dl_a[12]) : '0;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // one fill; leaves the bench in cycle 18 at a negedge
  task automatic run_fill(input logic [15:0] base, input logic [5:0] off, input int busy_at);
    logic [1:0]  g0 = off[5:4];
    logic [15:0] seen = '0;
    start_i = 1'b1; base_i = base; offset_i = off;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
    for (int n = 0; n <= 18; n++) begin
      logic [1:0]  gr = 2'(g0 + n);
      logic [1:0]  gw = 2'(g0 + n - 14);
      logic [15:0] emask = (n < 4) ? (16'hF << (4 * gr)) : 16'h0;
      logic [21:0] eaddr = (n < 4) ? {base, gr, 4'h0} : 22'h0;
      logic        ewe = (n >= 14) && (n <= 17);
      chk(inhibit_o == (n < 18), (busy_at >= 0) ? "R7 inhibit" : "R2 inhibit", 256'(inhibit_o), 256'(n < 18));
      chk(bank_req_o == emask, "R3 bank_req", 256'(bank_req_o), 256'(emask));
      chk(req_addr_o == eaddr, "R3 req_addr", 256'(req_addr_o), 256'(eaddr));
      chk(buf_we_o == ewe, "R4 buf_we", 256'(buf_we_o), 256'(ewe));
      if (ewe) begin
        chk(buf_group_o == gw, "R5 group", 256'(buf_group_o), 256'(gw));
        chk(buf_wdata_o == pat({base, gw, 4'h0}), "R5 data", buf_wdata_o, pat({base, gw, 4'h0}));
      end
      chk(done_o == (n == 18), "R6 done", 256'(done_o), 256'(n == 18));
      chk((seen & bank_req_o) == 16'h0, "R9 bank reuse", 256'(seen & bank_req_o), 256'h0);
      seen |= bank_req_o;
      if (n == busy_at) begin
        start_i = 1'b1; base_i = ~base; offset_i = ~off;
      end else if (busy_at >= 0 && n == busy_at + 1) begin
        start_i = 1'b0; base_i = base; offset_i = off;
      end
      if (n < 18) begin @(posedge clk_i); @(negedge clk_i); end
    end
    chk(seen == 16'hFFFF, "R9 bank cover", 256'(seen), 256'hFFFF);
  endtask

  task automatic idle_check(input string req);
    repeat (3) begin
      @(posedge clk_i); @(negedge clk_i);
      chk(!inhibit_o && bank_req_o == 16'h0 && !buf_we_o && !done_o, req,
          256'({inhibit_o, bank_req_o, buf_we_o, done_o}), 256'h0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(!inhibit_o, "R1 inhibit", 256'(inhibit_o), 256'h0);
    chk(bank_req_o == 16'h0, "R1 bank_req", 256'(bank_req_o), 256'h0);
    chk(!buf_we_o, "R1 buf_we", 256'(buf_we_o), 256'h0);
    chk(!done_o, "R1 done", 256'(done_o), 256'h0);
    rst_ni = 1'b1;
    idle_check("R1 idle");
  endtask

  task automatic t_offsets();
    run_fill(16'h1234, 6'h00, -1); idle_check("R2 idle after");
    run_fill(16'hBEEF, 6'h2A, -1); idle_check("R2 idle after");
    run_fill(16'h0F0F, 6'h3F, -1); idle_check("R3 wrap idle");
    run_fill(16'hFFFF, 6'h15, -1); idle_check("R4 idle after");
  endtask

  task automatic t_busy_start();
    run_fill(16'h5A5A, 6'h1F, 2);  idle_check("R7 no extra fill");
    run_fill(16'hA5A5, 6'h33, 15); idle_check("R7 no extra fill");
  endtask

  task automatic t_back_to_back();
    run_fill(16'h0101, 6'h20, -1);
    run_fill(16'h0202, 6'h35, -1);
    run_fill(16'h0303, 6'h0C, -1);
    idle_check("R8 idle after chain");
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_offsets();
    t_busy_start();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule